// File: doc/BRIEF.md
# Register Bitfield Operation Unit

This unit performs one of eight bitfield operations on a 32-bit data register value. It can test the field, extract it unsigned or signed, invert, clear or set its bits, insert new bits into it, or find its first set bit. A field is named by a start position and a length. Positions count from the most significant bit: position 0 is bit 31. A field that runs past bit 0 wraps around to bit 31. The start position and the length each come either from an immediate field of the instruction's extension word or from a data register value. The choice is made separately for each of the two.

The unit accepts one operation per cycle when `opValid` is high and registers its results one clock later. It returns the updated destination value with a write enable, a result value with a write enable, and negative and zero flags. The flags describe the field as it was before any change. Instruction fetch, opcode decode and the register file are outside the unit. The surrounding logic reads the registers and passes in their values together with the low twelve bits of the extension word. Only the low five bits of the offset and width registers are passed in, because both are used modulo 32.

Top module: `bfu_unit`

## Requirements
- R1: While `rstN` is low and after its release, `outValid`, `dstWe`, `resWe`, `flagN`, `flagZ`, `dstOut` and `resOut` are all 0 until the first accepted operation.
- R2: An operation accepted on a rising edge with `opValid` high shows its results on the outputs after that edge, with `outValid` high for exactly one cycle. With `opValid` low, `outValid`, `dstWe` and `resWe` are low on the next cycle.
- R3: When `extLow[11]` is 1, the start position is `offReg` (the offset register modulo 32) and `extLow[10:6]` is ignored. When `extLow[11]` is 0, the start position is `extLow[10:6]`.
- R4: When `extLow[5]` is 1, the length code is `widReg`. When it is 0, the length code is `extLow[4:0]`. A code of 0 means a length of 32, and any other code is the length itself.
- R5: `flagN` is the field's first (most significant) bit and `flagZ` is 1 exactly when every field bit is 0. Both are taken from `dstIn` before any modification, for every opcode.
- R6: Opcode 1 writes `resOut` with the field right-justified and zero-filled, and raises `resWe`.
- R7: Opcode 3 writes `resOut` with the field right-justified and sign-extended from its first bit, and raises `resWe`.
- R8: Opcodes 2, 4 and 6 write `dstOut` with the field bits inverted, cleared or set, in that order of opcodes. Bits outside the field keep their values, including when the field wraps past bit 0. `dstWe` is raised.
- R9: Opcode 7 writes `dstOut` with the field replaced by the low `length` bits of `srcIn`. The most significant of those bits goes to the field's first position, the rest of `dstIn` is kept, and `dstWe` is raised.
- R10: Opcode 5 writes `resOut` with the start position plus the index, counted from the field's first bit, of the first set field bit. When no field bit is set, the value is the start position plus the length. `resWe` is raised.
- R11: Opcode 0 raises neither write enable but still updates the flags.
- R12: `dstWe` and `resWe` are never high together. `dstWe` is raised only for opcodes 2, 4, 6 and 7, and `resWe` only for opcodes 1, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Accept an operation this cycle |
| opCode | input | 3 | Operation select (0 test, 1 unsigned extract, 2 invert, 3 signed extract, 4 clear, 5 first one, 6 set, 7 insert) |
| extLow | input | 12 | Extension word bits 11:0 |
| dstIn | input | 32 | Destination register value |
| srcIn | input | 32 | Insert source register value |
| offReg | input | 5 | Offset register value modulo 32 |
| widReg | input | 5 | Width register value modulo 32 |
| dstOut | output | 32 | Updated destination value |
| dstWe | output | 1 | Destination write enable |
| resOut | output | 32 | Result register value |
| resWe | output | 1 | Result write enable |
| flagN | output | 1 | Field first bit |
| flagZ | output | 1 | Field is all zero |
| outValid | output | 1 | Outputs hold a fresh result |

## Verification
Every opcode is run over every start position and every length in immediate mode, on two data words. The first word has only its two end bits set. It separates fields that touch or wrap past bit 0 from fields that do not, and it finds off-by-one errors in the first-one index and the not-found case. The second word is dense and irregular. It catches wrong bit order in insert and extract and shows whether sign extension starts at the right bit. A second sweep takes the position and length from the register inputs and puts contrary values in the immediate fields, so a wrong source select changes the result.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    FLD_KEEP   = 3'd0,
    FLD_INVERT = 3'd1,
    FLD_CLEAR  = 3'd2,
    FLD_SET    = 3'd3,
    FLD_INSERT = 3'd4
  } fieldAct_e;

  typedef enum logic [1:0] {
    RES_UNSIGNED = 2'd0,
    RES_SIGNED   = 2'd1,
    RES_FIRSTONE = 2'd2
  } resSel_e;

  typedef struct packed {
    logic      offFromReg;
    logic      widFromReg;
    logic      wrDst;
    logic      wrRes;
    fieldAct_e fieldAct;
    resSel_e   resSel;
  } bfuCtrl_t;

endpackage

// File: rtl/bfu_ctrl.sv
module bfu_ctrl
  import bfu_pkg::*;
(
  input  logic [2:0] opCode,
  input  logic       offSel,
  input  logic       widSel,
  output bfuCtrl_t   ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.offFromReg = offSel;
    ctrl.widFromReg = widSel;
    ctrl.fieldAct   = FLD_KEEP;
    ctrl.resSel     = RES_UNSIGNED;
    unique case (opCode)
      3'd0: ;
      3'd1: begin ctrl.wrRes = 1'b1; ctrl.resSel = RES_UNSIGNED; end
      3'd2: begin ctrl.wrDst = 1'b1; ctrl.fieldAct = FLD_INVERT; end
      3'd3: begin ctrl.wrRes = 1'b1; ctrl.resSel = RES_SIGNED; end
      3'd4: begin ctrl.wrDst = 1'b1; ctrl.fieldAct = FLD_CLEAR; end
      3'd5: begin ctrl.wrRes = 1'b1; ctrl.resSel = RES_FIRSTONE; end
      3'd6: begin ctrl.wrDst = 1'b1; ctrl.fieldAct = FLD_SET; end
      default: begin ctrl.wrDst = 1'b1; ctrl.fieldAct = FLD_INSERT; end
    endcase
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       opValid,
  input  bfuCtrl_t                   ctrl,
  input  logic [$clog2(DATA_W)-1:0]  immOff,
  input  logic [$clog2(DATA_W)-1:0]  immWid,
  input  logic [$clog2(DATA_W)-1:0]  offReg,
  input  logic [$clog2(DATA_W)-1:0]  widReg,
  input  logic [DATA_W-1:0]          dstIn,
  input  logic [DATA_W-1:0]          srcIn,
  output logic [DATA_W-1:0]          dstOut,
  output logic                       dstWe,
  output logic [DATA_W-1:0]          resOut,
  output logic                       resWe,
  output logic                       flagN,
  output logic                       flagZ,
  output logic                       outValid
);

  localparam int POS_W = $clog2(DATA_W);
  localparam int IDX_W = POS_W + 1;

  function automatic logic [DATA_W-1:0] rotRight(input logic [DATA_W-1:0] v,
                                                 input logic [IDX_W-1:0] amt);
    return (v >> amt) | (v << (IDX_W'(DATA_W) - amt));
  endfunction

  function automatic logic [DATA_W-1:0] rotLeft(input logic [DATA_W-1:0] v,
                                                input logic [IDX_W-1:0] amt);
    return (v << amt) | (v >> (IDX_W'(DATA_W) - amt));
  endfunction

  logic [POS_W-1:0]  startPos;
  logic [POS_W-1:0]  lenCode;
  logic [IDX_W-1:0]  lenVal;
  logic [IDX_W-1:0]  padBits;
  logic [DATA_W-1:0] topMask;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] leftJust;
  logic [DATA_W-1:0] insBits;
  logic [IDX_W-1:0]  firstIdx;
  logic [IDX_W-1:0]  firstSum;
  logic [DATA_W-1:0] nextDst;
  logic [DATA_W-1:0] nextRes;

  assign startPos  = ctrl.offFromReg ? offReg : immOff;
  assign lenCode   = ctrl.widFromReg ? widReg : immWid;
  assign lenVal    = (lenCode == '0) ? IDX_W'(DATA_W) : {1'b0, lenCode};
  assign padBits   = IDX_W'(DATA_W) - lenVal;
  assign topMask   = {DATA_W{1'b1}} << padBits;
  assign fieldMask = rotRight(topMask, {1'b0, startPos});
  assign leftJust  = rotLeft(dstIn & fieldMask, {1'b0, startPos});

  // Low lenVal bits of the source, rotated so its top bit lands at startPos.
  assign insBits = rotRight(srcIn & (topMask >> padBits),
                            {1'b0, POS_W'({1'b0, startPos} + lenVal)});

  always_comb begin
    firstIdx = lenVal;
    for (int i = 0; i < DATA_W; i++) begin
      if (leftJust[i]) firstIdx = IDX_W'(DATA_W - 1 - i);
    end
  end

  assign firstSum = {1'b0, startPos} + firstIdx;

  always_comb begin
    unique case (ctrl.fieldAct)
      FLD_INVERT: nextDst = dstIn ^ fieldMask;
      FLD_CLEAR:  nextDst = dstIn & ~fieldMask;
      FLD_SET:    nextDst = dstIn | fieldMask;
      FLD_INSERT: nextDst = (dstIn & ~fieldMask) | insBits;
      default:    nextDst = dstIn;
    endcase
  end

  always_comb begin
    unique case (ctrl.resSel)
      RES_SIGNED:   nextRes = $unsigned($signed(leftJust) >>> padBits);
      RES_FIRSTONE: nextRes = DATA_W'(firstSum);
      default:      nextRes = leftJust >> padBits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstOut   <= '0;
      resOut   <= '0;
      dstWe    <= 1'b0;
      resWe    <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= opValid;
      dstWe    <= opValid & ctrl.wrDst;
      resWe    <= opValid & ctrl.wrRes;
      if (opValid) begin
        flagN <= leftJust[DATA_W-1];
        flagZ <= (leftJust == '0);
        if (ctrl.wrDst) dstOut <= nextDst;
        if (ctrl.wrRes) resOut <= nextRes;
      end
    end
  end

  assert_one_writer_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(dstWe && resWe));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> outValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!outValid && !dstWe && !resWe));

  assert_zero_not_neg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagZ) |-> !flagN);

  assert_we_needs_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dstWe || resWe) |-> outValid);

endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
  import bfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [11:0]       extLow,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [POS_W-1:0]  offReg,
  input  logic [POS_W-1:0]  widReg,
  output logic [DATA_W-1:0] dstOut,
  output logic              dstWe,
  output logic [DATA_W-1:0] resOut,
  output logic              resWe,
  output logic              flagN,
  output logic              flagZ,
  output logic              outValid
);

  bfuCtrl_t ctrl;

  bfu_ctrl i_ctrl (
    .opCode (opCode),
    .offSel (extLow[11]),
    .widSel (extLow[5]),
    .ctrl   (ctrl)
  );

  bfu_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .ctrl     (ctrl),
    .immOff   (extLow[10:6]),
    .immWid   (extLow[4:0]),
    .offReg   (offReg),
    .widReg   (widReg),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .dstOut   (dstOut),
    .dstWe    (dstWe),
    .resOut   (resOut),
    .resWe    (resWe),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .outValid (outValid)
  );

  assert_test_nowrite_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0) |=> (!dstWe && !resWe));

  assert_dst_ops_R12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd2 || opCode == 3'd4 || opCode == 3'd6 || opCode == 3'd7))
      |=> (dstWe && !resWe));

endmodule

// File: tb/test_bfu_unit.sv
module test_bfu_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [11:0] extLow = '0;
  logic [31:0] dstIn = '0;
  logic [31:0] srcIn = '0;
  logic [4:0]  offReg = '0;
  logic [4:0]  widReg = '0;
  logic [31:0] dstOut;
  logic        dstWe;
  logic [31:0] resOut;
  logic        resWe;
  logic        flagN;
  logic        flagZ;
  logic        outValid;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bfu_unit i_bfu_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .extLow(extLow),
    .dstIn(dstIn), .srcIn(srcIn), .offReg(offReg), .widReg(widReg),
    .dstOut(dstOut), .dstWe(dstWe), .resOut(resOut), .resWe(resWe),
    .flagN(flagN), .flagZ(flagZ), .outValid(outValid)
  );

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R11";
      3'd1: return "R6";
      3'd3: return "R7";
      3'd5: return "R10";
      3'd7: return "R9";
      default: return "R8";
    endcase
  endfunction

  // Bit-by-bit reference: field bit i sits at register bit 31-((off+i)%32).
  task automatic runOp(input logic [2:0] op, input int off, input int w,
                       input bit regMode, input logic [31:0] d, input logic [31:0] a);
    logic [31:0] fb;
    logic [31:0] expDst;
    logic [31:0] expRes;
    logic        expN, expZ, expDWe, expRWe;
    int          idx;
    int          pos;
    fb = '0;
    expDst = d;
    for (int i = 0; i < w; i++) begin
      pos = 31 - ((off + i) % 32);
      fb[i] = d[pos];
      case (op)
        3'd2: expDst[pos] = ~d[pos];
        3'd4: expDst[pos] = 1'b0;
        3'd6: expDst[pos] = 1'b1;
        3'd7: expDst[pos] = a[w - 1 - i];
        default: ;
      endcase
    end
    expN = fb[0];
    expZ = (fb == '0);
    expRes = '0;
    if (op == 3'd1 || op == 3'd3) begin
      for (int i = 0; i < w; i++) expRes[w - 1 - i] = fb[i];
      if (op == 3'd3 && expN) for (int j = w; j < 32; j++) expRes[j] = 1'b1;
    end
    if (op == 3'd5) begin
      idx = w;
      for (int i = w - 1; i >= 0; i--) if (fb[i]) idx = i;
      expRes = 32'(off + idx);
    end
    expDWe = (op == 3'd2 || op == 3'd4 || op == 3'd6 || op == 3'd7);
    expRWe = (op == 3'd1 || op == 3'd3 || op == 3'd5);

    @(negedge clk);
    opValid = 1'b1;
    opCode  = op;
    dstIn   = d;
    srcIn   = a;
    if (regMode) begin
      // Immediate fields hold contrary values that must be ignored (R3, R4).
      extLow = {1'b1, 5'(31 - off), 1'b1, 5'(w + 7)};
      offReg = 5'(off);
      widReg = 5'(w);
    end else begin
      extLow = {1'b0, 5'(off), 1'b0, 5'(w)};
      offReg = 5'(31 - off);
      widReg = 5'(w + 3);
    end
    @(negedge clk);
    opValid = 1'b0;

    nTests++;
    if (outValid !== 1'b1 || dstWe !== expDWe || resWe !== expRWe) begin
      nFails++;
      $display("FAIL R12 R2 op=%0d off=%0d w=%0d: v/dwe/rwe=%b%b%b expected 1%b%b",
               op, off, w, outValid, dstWe, resWe, expDWe, expRWe);
    end
    nTests++;
    if (flagN !== expN || flagZ !== expZ) begin
      nFails++;
      $display("FAIL R5 op=%0d off=%0d w=%0d: NZ=%b%b expected %b%b",
               op, off, w, flagN, flagZ, expN, expZ);
    end
    if (expDWe) begin
      nTests++;
      if (dstOut !== expDst) begin
        nFails++;
        $display("FAIL %s%s op=%0d off=%0d w=%0d: dst=%h expected %h",
                 opTag(op), regMode ? " R3 R4" : "", op, off, w, dstOut, expDst);
      end
    end
    if (expRWe) begin
      nTests++;
      if (resOut !== expRes) begin
        nFails++;
        $display("FAIL %s%s op=%0d off=%0d w=%0d: res=%h expected %h",
                 opTag(op), regMode ? " R3 R4" : "", op, off, w, resOut, expRes);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    nTests++;
    if (outValid !== 1'b0 || dstWe !== 1'b0 || resWe !== 1'b0 || flagN !== 1'b0 ||
        flagZ !== 1'b0 || dstOut !== '0 || resOut !== '0) begin
      nFails++;
      $display("FAIL R1 reset: v=%b dwe=%b rwe=%b n=%b z=%b dst=%h res=%h expected all 0",
               outValid, dstWe, resWe, flagN, flagZ, dstOut, resOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    nTests++;
    if (outValid !== 1'b0 || dstOut !== '0 || resOut !== '0) begin
      nFails++;
      $display("FAIL R1 after release: v=%b dst=%h res=%h expected 0", outValid, dstOut, resOut);
    end

    for (int p = 0; p < 2; p++)
      for (int op = 0; op < 8; op++)
        for (int off = 0; off < 32; off++)
          for (int w = 1; w <= 32; w++)
            runOp(3'(op), off, w, 1'b0,
                  p == 0 ? 32'h8000_0001 : 32'hA5C3_0F96,
                  p == 0 ? 32'hFFFF_FFFF : 32'h1357_9BDE);

    for (int op = 0; op < 8; op++)
      for (int off = 0; off < 32; off += 3)
        for (int w = 1; w <= 32; w++)
          runOp(3'(op), off, w, 1'b1, 32'h6C1E_93B5, 32'hC0DE_5A71);

    // R2: no new operation means outputs drop their valid and write enables
    @(negedge clk);
    nTests++;
    if (outValid !== 1'b0 || dstWe !== 1'b0 || resWe !== 1'b0) begin
      nFails++;
      $display("FAIL R2 idle: v/dwe/rwe=%b%b%b expected 000", outValid, dstWe, resWe);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired: ran out of cycles, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule